// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block serializes station-management frames onto a two-wire management bus (MDC clock, MDIO data) for a host that programs it through three simple register strobes. A configuration write selects clause 22 or clause 45 framing and whether a 32-bit preamble is sent. A write-data load supplies the 16-bit value for write frames, or the register address for clause 45 address frames. A command write then starts one frame. Two busy flags tell the host when a transmit-type frame or a read frame is still in flight. When a read finishes, a valid flag and a 16-bit result hold the outcome.

MDC is a free-running divided copy of the system clock. The master moves MDIO only in the clock cycle in which MDC falls, and it samples returned data at the cycle in which MDC rises. In clause 45 mode the same 5-bit register-address field carries the device address. The pad tristate sits outside the block, which exposes separate output, output-enable and input pins.

Top module: `mdio_master`

## Requirements
- R1: MDC is the system clock divided by the even parameter MDC_DIV, high for MDC_DIV/2 cycles and low for MDC_DIV/2 cycles, and it is low when reset is released.
- R2: mdio_out and mdio_oe change only in the system clock cycle in which MDC goes from 1 to 0.
- R3: With the preamble bit set, a frame begins with 32 bits of 1. With the bit clear, the frame begins directly with the start code.
- R4: A clause 22 frame carries, MSB first: start 01, wire opcode (command op 0 = write gives 01, command op 1 = read gives 10), 5-bit PHY address, 5-bit register address, turnaround, 16 data bits. A write uses turnaround 10 and takes its data from the write-data register.
- R5: A clause 45 frame has start 00 and puts the command op directly on the wire as the opcode (0 address, 1 write, 2 read with increment, 3 read). The register-address field is sent as the device address. Address and write frames use turnaround 10 and send the write-data register as the 16-bit field.
- R6: In a read frame the master releases MDIO (mdio_oe = 0) for both turnaround bits and all 16 data bits. It shifts in the line MSB first at each MDC rise. rd_data holds the 16 bits when rd_pending clears, and rd_valid is then 1.
- R7: If MDIO is not 0 during the second turnaround bit of a read, the read still completes, but rd_valid stays 0. rd_valid is cleared when a read command is accepted.
- R8: An accepted write or address command sets wr_pending, and an accepted read command sets rd_pending. The flag clears at the MDC fall after the last frame bit. The two flags are never set together.
- R9: A command write that arrives while either pending flag is set is ignored: no frame is started and no flag changes.
- R10: Reset (rst_n low at a clock edge) clears both pending flags and rd_valid, drives mdio_oe to 0, and keeps MDIO released whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the configuration bits |
| cfg_clause45 | input | 1 | 1 selects clause 45 framing, 0 clause 22 |
| cfg_preamble | input | 1 | 1 sends a 32-bit preamble before each frame |
| wdat_we | input | 1 | Load the write-data register |
| wdat_in | input | 16 | Write data or clause 45 register address |
| cmd_we | input | 1 | Command write; starts a frame when idle |
| cmd_op | input | 2 | Operation code of the command |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address (device address in clause 45) |
| wr_pending | output | 1 | Write or address frame in progress |
| rd_pending | output | 1 | Read frame in progress |
| rd_valid | output | 1 | Last read saw a proper turnaround |
| rd_data | output | 16 | Data from the last completed read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_in | input | 1 | Value observed on the MDIO line |

## Verification
The assertions assume that the host issues commands through one-cycle strobes and that the configuration and write-data registers are loaded before the command strobe, not during the frame. They also assume that mdio_in reflects the master's own drive while mdio_oe is high. The bench meets these assumptions. It loads configuration and data one cycle before each command and changes nothing until both pending flags are clear. The one exception is the deliberate overlapping command. Its bus model resolves the line as the master's value when enabled and the simulated device's value otherwise. The device changes its bit only just after an MDC fall, so the line is stable at every sampling rise.

// File: rtl/mdio_pkg.sv
// Shared constants, command type and framing helpers for the MDIO master.
// Assumes the standard 5-bit address fields and 16-bit data field.
package mdio_pkg;
    localparam int ADR_W     = 5;
    localparam int DAT_W     = 16;
    localparam int OP_W      = 2;
    localparam int PRE_BITS  = 32;
    localparam int BODY_BITS = 2 + 2 + ADR_W + ADR_W + 2 + DAT_W;
    localparam int MAX_BITS  = PRE_BITS + BODY_BITS;
    localparam int CNT_W     = $clog2(MAX_BITS + 1);
    // Position (bits remaining, counted from 1) of the first turnaround bit.
    localparam int TA1_POS   = DAT_W + 2;
    localparam int TA2_POS   = DAT_W + 1;

    localparam logic [1:0] START_C22 = 2'b01;
    localparam logic [1:0] START_C45 = 2'b00;
    localparam logic [1:0] TA_DRIVE  = 2'b10;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ADR_W-1:0] phy;
        logic [ADR_W-1:0] rega;
    } mdio_cmd_t;

    // Opcode as it appears on the wire for a given host command code.
    function automatic logic [1:0] wire_opcode(input logic c45, input logic [OP_W-1:0] op);
        if (c45) return op;
        return op[0] ? 2'b10 : 2'b01;
    endfunction

    // True when the host command code requests a read.
    function automatic logic op_is_read(input logic c45, input logic [OP_W-1:0] op);
        return c45 ? op[1] : op[0];
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
// Management clock divider. Produces MDC at clk/DIV with equal halves and
// one-cycle strobes marking the clock edge at which MDC rises or falls.
// Assumes DIV is even and at least 2.
module mdio_mdc_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign rise_tick = (cnt == CW'(HALF - 1));
    assign fall_tick = (cnt == CW'(DIV - 1));

    // Phase counter and MDC level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= fall_tick ? '0 : cnt + 1'b1;
            if (rise_tick)
                mdc <= 1'b1;
            else if (fall_tick)
                mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_host_regs.sv
// Host-visible configuration and write-data storage. The values are held
// until rewritten; the frame engine latches what it needs at command accept.
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_clause45,
    input  logic             cfg_preamble,
    input  logic             wdat_we,
    input  logic [DAT_W-1:0] wdat_in,
    output logic             c45_mode,
    output logic             pre_en,
    output logic [DAT_W-1:0] wdat
);
    // Configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c45_mode <= 1'b0;
            pre_en   <= 1'b0;
        end else if (cfg_we) begin
            c45_mode <= cfg_clause45;
            pre_en   <= cfg_preamble;
        end
    end

    // Write-data / clause 45 address register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdat <= '0;
        else if (wdat_we)
            wdat <= wdat_in;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame sequencer: accepts a command when idle, shifts preamble and frame
// bits out at each MDC fall, releases the line for read turnaround and
// data, samples the line at each MDC rise, and posts the read result.
// Assumes rise_tick and fall_tick never coincide.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             cmd_we,
    input  mdio_cmd_t        cmd,
    input  logic             c45_mode,
    input  logic             pre_en,
    input  logic [DAT_W-1:0] wdat,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             wr_pending,
    output logic             rd_pending,
    output logic             rd_valid,
    output logic [DAT_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] LEN_BODY = CNT_W'(BODY_BITS);
    localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(MAX_BITS);
    localparam logic [CNT_W-1:0] POS_TA1  = CNT_W'(TA1_POS);
    localparam logic [CNT_W-1:0] POS_TA2  = CNT_W'(TA2_POS);
    localparam logic [CNT_W-1:0] POS_D0   = CNT_W'(DAT_W);

    logic                 busy;
    logic                 accept;
    logic                 req_read;
    logic [BODY_BITS-1:0] frame_word;
    logic [BODY_BITS-1:0] shreg;
    logic [CNT_W-1:0]     remain;
    logic [CNT_W-1:0]     cur_pos;
    logic                 is_rd;
    logic                 ta_ok;
    logic [DAT_W-1:0]     cap;

    assign busy   = wr_pending | rd_pending;
    assign accept = cmd_we & ~busy;

    // Assemble the frame body for the command being offered.
    always_comb begin
        req_read   = op_is_read(c45_mode, cmd.op);
        frame_word = {c45_mode ? START_C45 : START_C22,
                      wire_opcode(c45_mode, cmd.op),
                      cmd.phy, cmd.rega,
                      req_read ? 2'b11 : TA_DRIVE,
                      req_read ? {DAT_W{1'b1}} : wdat};
    end

    // Command accept, bit shift-out at MDC fall and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            remain     <= '0;
            cur_pos    <= '0;
            is_rd      <= 1'b0;
            mdio_out   <= 1'b1;
            mdio_oe    <= 1'b0;
            wr_pending <= 1'b0;
            rd_pending <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else if (accept) begin
            shreg      <= frame_word;
            remain     <= pre_en ? LEN_FULL : LEN_BODY;
            cur_pos    <= '0;
            is_rd      <= req_read;
            wr_pending <= ~req_read;
            rd_pending <= req_read;
            if (req_read)
                rd_valid <= 1'b0;
        end else if (busy && fall_tick) begin
            if (remain == '0) begin
                mdio_oe    <= 1'b0;
                mdio_out   <= 1'b1;
                wr_pending <= 1'b0;
                rd_pending <= 1'b0;
                cur_pos    <= '0;
                if (is_rd) begin
                    rd_data  <= cap;
                    rd_valid <= ta_ok;
                end
            end else begin
                cur_pos <= remain;
                remain  <= remain - 1'b1;
                if (remain > LEN_BODY) begin
                    mdio_out <= 1'b1;
                    mdio_oe  <= 1'b1;
                end else begin
                    mdio_out <= shreg[BODY_BITS-1];
                    shreg    <= {shreg[BODY_BITS-2:0], 1'b0};
                    mdio_oe  <= ~(is_rd && (remain <= POS_TA1));
                end
            end
        end
    end

    // Line sampling at MDC rise during a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_ok <= 1'b0;
            cap   <= '0;
        end else if (accept) begin
            ta_ok <= 1'b0;
        end else if (rd_pending && rise_tick) begin
            if (cur_pos == POS_TA2)
                ta_ok <= ~mdio_in;
            else if (cur_pos != '0 && cur_pos <= POS_D0)
                cap <= {cap[DAT_W-2:0], mdio_in};
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Dual-clause MDIO master top: joins the MDC divider, host registers and
// frame engine. MDC_DIV must be even and at least 2.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_clause45,
    input  logic             cfg_preamble,
    input  logic             wdat_we,
    input  logic [DAT_W-1:0] wdat_in,
    input  logic             cmd_we,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [ADR_W-1:0] cmd_phy,
    input  logic [ADR_W-1:0] cmd_reg,
    output logic             wr_pending,
    output logic             rd_pending,
    output logic             rd_valid,
    output logic [DAT_W-1:0] rd_data,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic             mdio_in
);
    logic             rise_tick;
    logic             fall_tick;
    logic             c45_mode;
    logic             pre_en;
    logic [DAT_W-1:0] wdat;
    mdio_cmd_t        cmd;

    assign cmd = '{op: cmd_op, phy: cmd_phy, rega: cmd_reg};

    mdio_mdc_gen #(.DIV(MDC_DIV)) i_mdc_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_host_regs i_host_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_clause45 (cfg_clause45),
        .cfg_preamble (cfg_preamble),
        .wdat_we      (wdat_we),
        .wdat_in      (wdat_in),
        .c45_mode     (c45_mode),
        .pre_en       (pre_en),
        .wdat         (wdat)
    );

    mdio_frame_engine i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .cmd_we     (cmd_we),
        .cmd        (cmd),
        .c45_mode   (c45_mode),
        .pre_en     (pre_en),
        .wdat       (wdat),
        .mdio_in    (mdio_in),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .wr_pending (wr_pending),
        .rd_pending (rd_pending),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Protocol checker for mdio_master, attached by bind. Relates the
// pending flags, the output enable, MDC and the command strobe over time.
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_we,
    input logic wr_pending,
    input logic rd_pending,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe
);
    // R8: never both kinds of frame in flight.
    assert_one_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pending && rd_pending));

    // R10: the line is driven only while a frame is in progress.
    assert_oe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (wr_pending || rd_pending));

    // R2: MDIO drive changes only together with an MDC fall.
    assert_mdio_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_out) || !$stable(mdio_oe)) |-> $fell(mdc));

    // R9: a read starts only from a command seen while idle.
    assert_rd_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_pending) |-> ($past(cmd_we) && !$past(wr_pending)));

    // R9: a write or address frame starts only from a command seen while idle.
    assert_wr_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_pending) |-> ($past(cmd_we) && !$past(rd_pending)));
endmodule

bind mdio_master mdio_master_chk i_mdio_master_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .wr_pending (wr_pending),
    .rd_pending (rd_pending),
    .mdc        (mdc),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe)
);

// File: tb/test_mdio_master.sv
// Directed bench for mdio_master with a simple device model on the line.
module test_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_clause45 = 1'b0, cfg_preamble = 1'b0;
    logic        wdat_we = 1'b0;
    logic [15:0] wdat_in = '0;
    logic        cmd_we = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_phy = '0, cmd_reg = '0;
    logic        wr_pending, rd_pending, rd_valid;
    logic [15:0] rd_data;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    logic        phy_line = 1'b1;
    assign mdio_in = mdio_oe ? mdio_out : phy_line;

    mdio_master #(.MDC_DIV(DIV)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_clause45(cfg_clause45),
        .cfg_preamble(cfg_preamble), .wdat_we(wdat_we), .wdat_in(wdat_in),
        .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .wr_pending(wr_pending), .rd_pending(rd_pending), .rd_valid(rd_valid),
        .rd_data(rd_data), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .mdio_in(mdio_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          nchk = 0, nfail = 0;
    bit          finished = 0;
    int          cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bus monitor and device model state.
    logic        mdc_d = 1'b0, pend_d = 1'b0, out_d = 1'b1, oe_d = 1'b0;
    bit          frame_on = 0;
    int          ncap = 0;
    logic [63:0] cap = '0;
    int          pre_len = 0;
    bit          phy_rd_en = 0, phy_ta = 0, oe_in_data = 0;
    logic [15:0] phy_resp = '0;
    int          r2_viol = 0;
    int          last_rise = -1, rise_gap = 0, high_len = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: samples away from the active edge.
    always @(negedge clk) begin
        int  idx;
        bit  pend_now, rose, fell;
        pend_now = wr_pending | rd_pending;
        rose = mdc && !mdc_d;
        fell = !mdc && mdc_d;
        if (rst_n && ((mdio_out !== out_d) || (mdio_oe !== oe_d)) && !fell)
            r2_viol++;
        if (rose) begin
            if (last_rise >= 0) rise_gap = cyc - last_rise;
            last_rise = cyc;
        end
        if (fell && last_rise >= 0) high_len = cyc - last_rise;
        if (fell) begin
            frame_on = pend_d && pend_now;
            idx = ncap - pre_len;
            phy_line = 1'b1;
            if (frame_on && phy_rd_en) begin
                if (idx == 15) phy_line = phy_ta;
                else if (idx >= 16 && idx <= 31) phy_line = phy_resp[31 - idx];
            end
        end
        if (rose && frame_on) begin
            idx = ncap - pre_len;
            if (phy_rd_en && idx >= 14 && mdio_oe) oe_in_data = 1;
            cap = {cap[62:0], mdio_in};
            ncap++;
        end
        mdc_d = mdc; pend_d = pend_now; out_d = mdio_out; oe_d = mdio_oe;
    end

    function automatic logic [31:0] exp_body(input bit c45, input logic [1:0] op,
            input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        logic [1:0] st, wop;
        st  = c45 ? 2'b00 : 2'b01;
        wop = c45 ? op : (op[0] ? 2'b10 : 2'b01);
        return {st, wop, phy, ra, 2'b10, d};
    endfunction

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while ((wr_pending || rd_pending) && n < 5000);
        chk("R8 frame completes", (n < 5000), 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic start_frame(input bit c45, input bit pre, input logic [1:0] op,
            input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
            input bit rd, input logic [15:0] resp, input bit ta);
        @(negedge clk);
        ncap = 0; cap = '0; pre_len = pre ? 32 : 0; oe_in_data = 0;
        phy_rd_en = rd; phy_ta = ta; phy_resp = resp;
        cfg_we = 1; cfg_clause45 = c45; cfg_preamble = pre; wdat_we = 1; wdat_in = wd;
        @(negedge clk);
        cfg_we = 0; wdat_we = 0;
        cmd_we = 1; cmd_op = op; cmd_phy = phy; cmd_reg = ra;
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic test_reset();
        chk("R10 wr_pending after reset", wr_pending, 0);
        chk("R10 rd_pending after reset", rd_pending, 0);
        chk("R10 rd_valid after reset", rd_valid, 0);
        chk("R10 mdio_oe after reset", mdio_oe, 0);
        chk("R1 mdc low after reset", mdc, 0);
    endtask

    task automatic test_c22_write(input bit pre);
        start_frame(0, pre, 2'd0, 5'h13, 5'h0A, 16'hA5C3, 0, '0, 0);
        chk("R8 wr_pending during write", {wr_pending, rd_pending}, 2'b10);
        wait_idle();
        chk("R3 frame length", ncap, pre ? 64 : 32);
        if (pre) chk("R3 preamble ones", cap[63:32], 32'hFFFF_FFFF);
        chk("R4 clause22 write frame", cap[31:0], exp_body(0, 2'd0, 5'h13, 5'h0A, 16'hA5C3));
    endtask

    task automatic test_c22_read();
        start_frame(0, 0, 2'd1, 5'h05, 5'h1F, 16'h0000, 1, 16'h9E21, 0);
        chk("R8 rd_pending during read", {wr_pending, rd_pending}, 2'b01);
        wait_idle();
        chk("R4 clause22 read header", cap[31:18], exp_body(0, 2'd1, 5'h05, 5'h1F, 0) >> 18);
        chk("R6 read data", rd_data, 16'h9E21);
        chk("R6 read valid", rd_valid, 1);
        chk("R6 line released in turnaround/data", oe_in_data, 0);
    endtask

    task automatic test_c45_addr_write();
        start_frame(1, 1, 2'd0, 5'h02, 5'h03, 16'h1234, 0, '0, 0);
        wait_idle();
        chk("R3 clause45 preamble length", ncap, 64);
        chk("R5 clause45 address frame", cap[31:0], exp_body(1, 2'd0, 5'h02, 5'h03, 16'h1234));
        start_frame(1, 0, 2'd1, 5'h1E, 5'h01, 16'hFEDC, 0, '0, 0);
        wait_idle();
        chk("R5 clause45 write frame", cap[31:0], exp_body(1, 2'd1, 5'h1E, 5'h01, 16'hFEDC));
    endtask

    task automatic test_c45_reads();
        start_frame(1, 1, 2'd2, 5'h07, 5'h1D, 16'h0, 1, 16'h0F0F, 0);
        wait_idle();
        chk("R5 clause45 read-inc header", cap[31:18], exp_body(1, 2'd2, 5'h07, 5'h1D, 0) >> 18);
        chk("R6 clause45 read-inc data", rd_data, 16'h0F0F);
        chk("R6 clause45 read-inc valid", rd_valid, 1);
        start_frame(1, 0, 2'd3, 5'h01, 5'h04, 16'h0, 1, 16'h8001, 0);
        wait_idle();
        chk("R5 clause45 read header", cap[31:18], exp_body(1, 2'd3, 5'h01, 5'h04, 0) >> 18);
        chk("R6 clause45 read data", rd_data, 16'h8001);
    endtask

    task automatic test_ta_fault();
        start_frame(1, 0, 2'd3, 5'h09, 5'h02, 16'h0, 1, 16'h5555, 1);
        chk("R7 valid cleared at read accept", rd_valid, 0);
        wait_idle();
        chk("R7 turnaround fault leaves valid low", rd_valid, 0);
        chk("R7 read completes", rd_pending, 0);
    endtask

    task automatic test_ignore_busy();
        start_frame(0, 0, 2'd0, 5'h11, 5'h06, 16'h3C3C, 0, '0, 0);
        repeat (20) @(negedge clk);
        cmd_we = 1; cmd_op = 2'd1; cmd_phy = 5'h00; cmd_reg = 5'h00;
        @(negedge clk);
        cmd_we = 0;
        @(negedge clk);
        chk("R9 read command ignored while busy", {wr_pending, rd_pending}, 2'b10);
        wait_idle();
        chk("R9 only one frame sent", ncap, 32);
        chk("R9 original frame intact", cap[31:0], exp_body(0, 2'd0, 5'h11, 5'h06, 16'h3C3C));
        chk("R9 no read started afterwards", rd_pending, 0);
    endtask

    task automatic test_mdc();
        chk("R1 mdc period", rise_gap, DIV);
        chk("R1 mdc high time", high_len, DIV / 2);
        chk("R2 mdio moves only at mdc fall", r2_viol, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_c22_write(0);
        test_c22_write(1);
        test_c22_read();
        test_c45_addr_write();
        test_c45_reads();
        test_ta_fault();
        test_ignore_busy();
        test_mdc();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule